// File: doc/BRIEF.md
# Serial Link Test-Pattern Generator

This block drives a one-bit-per-clock serial stream of fixed physical-layer test patterns. It is used to exercise a transmitter and the receiver at the far end during characterisation. A 4-bit select input picks one of fourteen patterns, and a start pulse restarts the chosen pattern from its first bit. Two sideband flags tell the analog driver whether to apply de-emphasis, pre-shoot, both or neither. The flags are fixed for each pattern.

The patterns fall into four families:
- Repeated 10-bit line-code symbols: D10.2, D24.3, K28.5, and K28.7 with and without de-emphasis. Each symbol alternates between its negative-disparity and positive-disparity forms so the stream stays DC balanced.
- Raw repeated bytes, sent without any block code: AAh and CCh.
- An uncoded 15-stage LFSR with polynomial x^15 + x^14 + 1.
- Symmetric long-run patterns. These are either a programmable run of N ones then N zeros, or a fixed run of LONG_HALF ones then LONG_HALF zeros (64 by default) in four equalisation variants.

A new select value is not applied at once. It is adopted only at the end of the current unit, and the new pattern then begins at its first bit.

The controller is a state machine with six states:
- IDLE: reset state. The output is quiet.
- SYMBOL: shifts out a 10-bit symbol.
- BYTE: shifts out a raw byte.
- PRBS: steps the LFSR.
- RUN_HI: emits the ones half of a long-run pattern.
- RUN_LO: emits the zeros half of a long-run pattern.

The transitions are:
- START: start is high. The block goes from any state to the state of the selected family.
- SYMBOL to SYMBOL: at the last bit of a symbol, with the disparity form toggled.
- BYTE to BYTE: at the last bit of a byte.
- PRBS to PRBS: on every bit.
- RUN_HI to RUN_LO: after N ones.
- RUN_LO to RUN_HI: after N zeros.
- SWITCH: at a unit end with a changed select. The block moves to the new family, or to IDLE for a reserved code.

IDLE is left only by START.

Top module: `ltp_gen`

## Requirements
- R1: After reset, ser_o, deemph_o and preshoot_o are 0, and they stay 0 until the first start pulse.
- R2: Codes 0 to 4 emit 10-bit symbols, written here in transmission order a..j, with bit a sent first. Forms alternate, starting with the first form.
  - Code 0 (D10.2): 0101010101 in both forms.
  - Code 1 (D24.3): 1100110011 and 0011001100.
  - Code 2 (K28.5): 0011111010 and 1100000101.
  - Codes 3 and 4 (K28.7): 0011111000 and 1100000111.
- R3: Code 7 repeats byte AAh and code 8 repeats byte CCh, least significant bit first, with no line coding.
- R4: Code 9 emits an LFSR stream o(n). The first 15 bits after loading are 1, then o(n+15) = o(n) XOR o(n+1). The LFSR state is never all zeros.
- R5: Codes 5 and 6 emit N ones then N zeros, repeating.
  - N is run_len_i clamped to the range RUN_MIN to RUN_MAX (50 to 250 by default).
  - N is captured when the pattern is loaded. Later changes of run_len_i have no effect until the next load.
- R6: Codes 10 to 13 emit LONG_HALF ones then LONG_HALF zeros, repeating.
- R7: The sideband flags depend only on the loaded pattern.
  - deemph_o is 1 for codes 3, 5, 11 and 12.
  - preshoot_o is 1 for codes 10 and 12.
  - Both flags are 0 for every other code.
- R8: A start pulse sampled at a clock edge makes the output after that edge the first bit of the selected pattern, whatever the current position.
- R9: A select change without start is adopted only at a unit end, and the new pattern starts at bit 0. The unit length depends on the family:
  - 10 bits for symbols.
  - 8 bits for raw bytes.
  - 1 bit for the LFSR.
  - one full ones-plus-zeros period for the long-run patterns.
- R10: Codes 14 and 15 are reserved. They give ser_o = 0 with both flags 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Restart the selected pattern from bit 0 |
| sel_i | input | 4 | Pattern code |
| run_len_i | input | RUN_W | Half-period N for codes 5 and 6, before clamping |
| ser_o | output | 1 | Serial test bit |
| deemph_o | output | 1 | De-emphasis request to the driver |
| preshoot_o | output | 1 | Pre-shoot request to the driver |

## Verification
The bench builds the block with RUN_W = 4, RUN_MIN = 4, RUN_MAX = 12 and LONG_HALF = 8. This shrinks the long-run periods to a few dozen bits, so every pattern code, including the reserved ones, can be checked bit by bit over several periods.

With a 4-bit run-length input, every programmable value from 0 to 15 can be swept. That covers clamping at both limits and every in-range N.

Mid-unit select changes and restarts are placed inside symbols, inside bytes and inside long-run periods. The expected streams are computed arithmetically from the symbol strings, the byte values and the LFSR recurrence.

// File: rtl/ltp_pkg.sv
package ltp_pkg;

    localparam int PAT_W     = 4;
    localparam int SYM_BITS  = 10;
    localparam int BYTE_BITS = 8;

    localparam logic [PAT_W-1:0] PAT_NYQ_SYM  = 4'd0;
    localparam logic [PAT_W-1:0] PAT_HALF_SYM = 4'd1;
    localparam logic [PAT_W-1:0] PAT_COMMA    = 4'd2;
    localparam logic [PAT_W-1:0] PAT_K7_DE    = 4'd3;
    localparam logic [PAT_W-1:0] PAT_K7_FLAT  = 4'd4;
    localparam logic [PAT_W-1:0] PAT_RUN_DE   = 4'd5;
    localparam logic [PAT_W-1:0] PAT_RUN_FLAT = 4'd6;
    localparam logic [PAT_W-1:0] PAT_NYQ_RAW  = 4'd7;
    localparam logic [PAT_W-1:0] PAT_HALF_RAW = 4'd8;
    localparam logic [PAT_W-1:0] PAT_PRBS15   = 4'd9;
    localparam logic [PAT_W-1:0] PAT_L64_PRE  = 4'd10;
    localparam logic [PAT_W-1:0] PAT_L64_DE   = 4'd11;
    localparam logic [PAT_W-1:0] PAT_L64_BOTH = 4'd12;
    localparam logic [PAT_W-1:0] PAT_L64_NONE = 4'd13;
    localparam logic [PAT_W-1:0] PAT_PARKED   = 4'd15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYMBOL,
        ST_BYTE,
        ST_PRBS,
        ST_RUN_HI,
        ST_RUN_LO
    } ltp_state_e;

    // Family state entered when a pattern code is loaded.
    function automatic ltp_state_e family_of(logic [PAT_W-1:0] code);
        ltp_state_e s;
        case (code)
            PAT_NYQ_SYM, PAT_HALF_SYM, PAT_COMMA,
            PAT_K7_DE, PAT_K7_FLAT:                  s = ST_SYMBOL;
            PAT_NYQ_RAW, PAT_HALF_RAW:               s = ST_BYTE;
            PAT_PRBS15:                              s = ST_PRBS;
            PAT_RUN_DE, PAT_RUN_FLAT,
            PAT_L64_PRE, PAT_L64_DE,
            PAT_L64_BOTH, PAT_L64_NONE:              s = ST_RUN_HI;
            default:                                 s = ST_IDLE;
        endcase
        return s;
    endfunction

    function automatic logic is_prog_run(logic [PAT_W-1:0] code);
        return (code == PAT_RUN_DE) || (code == PAT_RUN_FLAT);
    endfunction

    function automatic logic wants_deemph(logic [PAT_W-1:0] code);
        return (code == PAT_K7_DE) || (code == PAT_RUN_DE) ||
               (code == PAT_L64_DE) || (code == PAT_L64_BOTH);
    endfunction

    function automatic logic wants_preshoot(logic [PAT_W-1:0] code);
        return (code == PAT_L64_PRE) || (code == PAT_L64_BOTH);
    endfunction

endpackage

// File: rtl/ltp_symbol_rom.sv
// Bit lookup for the fixed-symbol and raw-byte families.
module ltp_symbol_rom
    import ltp_pkg::*;
(
    input  logic [PAT_W-1:0] pat_i,
    input  logic             odd_i,
    input  logic [3:0]       idx_i,
    output logic             bit_o
);

    logic [SYM_BITS-1:0]  sym_aj;   // written in a..j order, a at the MSB
    logic [SYM_BITS-1:0]  sym_lin;  // bit k is the k-th transmitted bit
    logic [BYTE_BITS-1:0] raw_byte;
    logic                 is_raw;
    logic [15:0]          lin;

    always_comb begin
        sym_aj = '0;
        case (pat_i)
            PAT_NYQ_SYM:  sym_aj = 10'b0101010101;
            PAT_HALF_SYM: sym_aj = odd_i ? 10'b0011001100 : 10'b1100110011;
            PAT_COMMA:    sym_aj = odd_i ? 10'b1100000101 : 10'b0011111010;
            PAT_K7_DE,
            PAT_K7_FLAT:  sym_aj = odd_i ? 10'b1100000111 : 10'b0011111000;
            default:      sym_aj = '0;
        endcase
    end

    for (genvar k = 0; k < SYM_BITS; k++) begin : g_order
        assign sym_lin[k] = sym_aj[SYM_BITS-1-k];
    end

    always_comb begin
        raw_byte = '0;
        is_raw   = 1'b0;
        case (pat_i)
            PAT_NYQ_RAW:  begin raw_byte = 8'hAA; is_raw = 1'b1; end
            PAT_HALF_RAW: begin raw_byte = 8'hCC; is_raw = 1'b1; end
            default:      begin raw_byte = '0;    is_raw = 1'b0; end
        endcase
    end

    always_comb begin
        if (is_raw) lin = {8'b0, raw_byte};
        else        lin = {6'b0, sym_lin};
        bit_o = lin[idx_i];
    end

endmodule

// File: rtl/ltp_run_clamp.sv
// Limits the programmed half-period to the legal window.
module ltp_run_clamp #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 8,
    parameter int LO    = 50,
    parameter int HI    = 250
) (
    input  logic [IN_W-1:0]  len_i,
    output logic [OUT_W-1:0] len_o
);

    int unsigned req;
    int unsigned lim;

    always_comb begin
        req = 32'(len_i);
        if (req < LO)      lim = LO;
        else if (req > HI) lim = HI;
        else               lim = req;
        len_o = OUT_W'(lim);
    end

endmodule

// File: rtl/ltp_lfsr.sv
// Fibonacci shift register; output is the MSB, feedback enters at bit 0.
module ltp_lfsr #(
    parameter int W      = 15,
    parameter int TAP_HI = 14,
    parameter int TAP_LO = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed_i,
    input  logic step_i,
    output logic bit_o
);

    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n || seed_i) q <= '1;
        else if (step_i)      q <= {q[W-2:0], q[TAP_HI] ^ q[TAP_LO]};
    end

    assign bit_o = q[W-1];

endmodule

// File: rtl/ltp_gen.sv
module ltp_gen
    import ltp_pkg::*;
#(
    parameter int RUN_W     = 8,
    parameter int RUN_MIN   = 50,
    parameter int RUN_MAX   = 250,
    parameter int LONG_HALF = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PAT_W-1:0] sel_i,
    input  logic [RUN_W-1:0] run_len_i,
    output logic             ser_o,
    output logic             deemph_o,
    output logic             preshoot_o
);

    localparam int HALF_MAX  = (RUN_MAX > LONG_HALF) ? RUN_MAX : LONG_HALF;
    localparam int CNT_W_RAW = $clog2(HALF_MAX + 1);
    localparam int CNT_W     = (CNT_W_RAW < 4) ? 4 : CNT_W_RAW;
    localparam logic [CNT_W-1:0] SYM_LAST  = CNT_W'(SYM_BITS - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    ltp_state_e        st, st_n;
    logic [PAT_W-1:0]  pat_q, pat_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [CNT_W-1:0]  run_len_q, run_len_n;
    logic              rd_q, rd_n;
    logic              load, lfsr_step;
    logic [CNT_W-1:0]  clamped_len;
    logic              rom_bit, prbs_bit;
    logic [CNT_W-1:0]  half_last;

    ltp_run_clamp #(
        .IN_W (RUN_W),
        .OUT_W(CNT_W),
        .LO   (RUN_MIN),
        .HI   (RUN_MAX)
    ) u_clamp (
        .len_i(run_len_i),
        .len_o(clamped_len)
    );

    ltp_symbol_rom u_rom (
        .pat_i(pat_q),
        .odd_i(rd_q),
        .idx_i(cnt[3:0]),
        .bit_o(rom_bit)
    );

    ltp_lfsr #(
        .W     (15),
        .TAP_HI(14),
        .TAP_LO(13)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .seed_i(load),
        .step_i(lfsr_step),
        .bit_o (prbs_bit)
    );

    assign half_last = run_len_q - CNT_ONE;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            pat_q     <= PAT_PARKED;
            cnt       <= '0;
            rd_q      <= 1'b0;
            run_len_q <= CNT_W'(LONG_HALF);
        end else begin
            st        <= st_n;
            pat_q     <= pat_n;
            cnt       <= cnt_n;
            rd_q      <= rd_n;
            run_len_q <= run_len_n;
        end
    end

    // Next-state logic
    always_comb begin
        st_n      = st;
        pat_n     = pat_q;
        cnt_n     = cnt;
        rd_n      = rd_q;
        run_len_n = run_len_q;
        load      = 1'b0;
        lfsr_step = 1'b0;

        if (start_i) begin
            load = 1'b1;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    cnt_n = '0;
                end
                ST_SYMBOL: begin
                    if (cnt == SYM_LAST) begin
                        if (sel_i != pat_q) load = 1'b1;
                        else begin
                            cnt_n = '0;
                            rd_n  = ~rd_q;
                        end
                    end else begin
                        cnt_n = cnt + CNT_ONE;
                    end
                end
                ST_BYTE: begin
                    if (cnt == BYTE_LAST) begin
                        if (sel_i != pat_q) load = 1'b1;
                        else                cnt_n = '0;
                    end else begin
                        cnt_n = cnt + CNT_ONE;
                    end
                end
                ST_PRBS: begin
                    if (sel_i != pat_q) load = 1'b1;
                    else                lfsr_step = 1'b1;
                end
                ST_RUN_HI: begin
                    if (cnt == half_last) begin
                        st_n  = ST_RUN_LO;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + CNT_ONE;
                    end
                end
                ST_RUN_LO: begin
                    if (cnt == half_last) begin
                        if (sel_i != pat_q) load = 1'b1;
                        else begin
                            st_n  = ST_RUN_HI;
                            cnt_n = '0;
                        end
                    end else begin
                        cnt_n = cnt + CNT_ONE;
                    end
                end
                default: begin
                    st_n = ST_IDLE;
                end
            endcase
        end

        if (load) begin
            pat_n     = sel_i;
            st_n      = family_of(sel_i);
            cnt_n     = '0;
            rd_n      = 1'b0;
            run_len_n = is_prog_run(sel_i) ? clamped_len : CNT_W'(LONG_HALF);
        end
    end

    // Outputs
    always_comb begin
        ser_o      = 1'b0;
        deemph_o   = 1'b0;
        preshoot_o = 1'b0;
        unique case (st)
            ST_IDLE:   ser_o = 1'b0;
            ST_SYMBOL,
            ST_BYTE:   ser_o = rom_bit;
            ST_PRBS:   ser_o = prbs_bit;
            ST_RUN_HI: ser_o = 1'b1;
            ST_RUN_LO: ser_o = 1'b0;
            default:   ser_o = 1'b0;
        endcase
        if (st != ST_IDLE) begin
            deemph_o   = wants_deemph(pat_q);
            preshoot_o = wants_preshoot(pat_q);
        end
    end

endmodule

// File: rtl/ltp_gen_chk.sv
module ltp_gen_chk
    import ltp_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int RUN_MIN = 50,
    parameter int RUN_MAX = 250
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input ltp_state_e       st,
    input logic [PAT_W-1:0] pat_q,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] run_len_q,
    input logic             ser_o,
    input logic             deemph_o,
    input logic             preshoot_o
);

    // R10 / R1: the parked state keeps the line and both flags low
    p_idle_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!ser_o && !deemph_o && !preshoot_o));

    // R7: pre-shoot is only ever requested by a long-run pattern
    p_preshoot_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
        preshoot_o |-> (st == ST_RUN_HI || st == ST_RUN_LO));

    // R9: no pattern change inside a symbol
    p_sym_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SYMBOL && int'(cnt) != SYM_BITS - 1 && !start_i)
        |=> (st == ST_SYMBOL && $stable(pat_q)));

    // R5: programmed half-period stays inside the legal window
    p_run_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pat_q == PAT_RUN_DE || pat_q == PAT_RUN_FLAT) &&
         (st == ST_RUN_HI || st == ST_RUN_LO))
        |-> (int'(run_len_q) >= RUN_MIN && int'(run_len_q) <= RUN_MAX));

    // R8: a start always lands on bit 0
    p_start_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt == '0));

endmodule

module ltp_lfsr_chk #(
    parameter int W = 15
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] q
);

    // R4: the register never locks up in the all-zero state
    p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);

endmodule

bind ltp_gen ltp_gen_chk #(
    .CNT_W  (CNT_W),
    .RUN_MIN(RUN_MIN),
    .RUN_MAX(RUN_MAX)
) u_gen_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .st        (st),
    .pat_q     (pat_q),
    .cnt       (cnt),
    .run_len_q (run_len_q),
    .ser_o     (ser_o),
    .deemph_o  (deemph_o),
    .preshoot_o(preshoot_o)
);

bind ltp_lfsr ltp_lfsr_chk #(
    .W(W)
) u_lfsr_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .q    (q)
);

// File: tb/ltp_gen_bench.sv
`timescale 1ns/1ps
module ltp_gen_bench;

    localparam int RUN_W  = 4;
    localparam int R_MIN  = 4;
    localparam int R_MAX  = 12;
    localparam int L_HALF = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [3:0]       sel_i = 4'd0;
    logic [RUN_W-1:0] run_len_i = '0;
    logic             ser_o, deemph_o, preshoot_o;

    int checks = 0;
    int failures = 0;
    int lf [0:511];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ltp_gen #(
        .RUN_W    (RUN_W),
        .RUN_MIN  (R_MIN),
        .RUN_MAX  (R_MAX),
        .LONG_HALF(L_HALF)
    ) u_ltp_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .sel_i     (sel_i),
        .run_len_i (run_len_i),
        .ser_o     (ser_o),
        .deemph_o  (deemph_o),
        .preshoot_o(preshoot_o)
    );

    task automatic check(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s got=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    function automatic int clampn(int v);
        if (v < R_MIN) return R_MIN;
        if (v > R_MAX) return R_MAX;
        return v;
    endfunction

    function automatic int exp_bit(int pat, int n, int halfn);
        logic [9:0] w;
        bit odd;
        odd = ((n / 10) % 2) == 1;
        w = '0;
        case (pat)
            0: w = 10'b0101010101;
            1: w = odd ? 10'b0011001100 : 10'b1100110011;
            2: w = odd ? 10'b1100000101 : 10'b0011111010;
            3, 4: w = odd ? 10'b1100000111 : 10'b0011111000;
            default: w = '0;
        endcase
        if (pat <= 4) return int'(w[9 - (n % 10)]);
        if (pat == 7) return int'((8'hAA >> (n % 8)) & 8'h01);
        if (pat == 8) return int'((8'hCC >> (n % 8)) & 8'h01);
        if (pat == 9) return lf[n];
        if (pat == 5 || pat == 6 || (pat >= 10 && pat <= 13))
            return ((n % (2 * halfn)) < halfn) ? 1 : 0;
        return 0;
    endfunction

    function automatic string req_of(int pat);
        if (pat <= 4) return "R2";
        if (pat == 7 || pat == 8) return "R3";
        if (pat == 9) return "R4";
        if (pat == 5 || pat == 6) return "R5";
        if (pat >= 10 && pat <= 13) return "R6";
        return "R10";
    endfunction

    task automatic start_pat(int p);
        @(negedge clk);
        sel_i   = 4'(p);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // At entry, bit 'from' is visible; leaves bit 'upto' visible.
    task automatic expect_stream(int pat, int halfn, int from, int upto, string req);
        for (int n = from; n < upto; n++) begin
            check(req, $sformatf("pat%0d bit%0d", pat, n), int'(ser_o), exp_bit(pat, n, halfn));
            @(negedge clk);
        end
    endtask

    task automatic expect_flags(int pat, string req);
        int de, pre;
        de  = (pat == 3 || pat == 5 || pat == 11 || pat == 12) ? 1 : 0;
        pre = (pat == 10 || pat == 12) ? 1 : 0;
        check(req, $sformatf("deemph pat%0d", pat), int'(deemph_o), de);
        check(req, $sformatf("preshoot pat%0d", pat), int'(preshoot_o), pre);
    endtask

    initial begin
        for (int i = 0; i < 512; i++)
            lf[i] = (i < 15) ? 1 : (lf[i-15] ^ lf[i-14]);

        // R1: reset state, and quiet until first start
        repeat (3) @(negedge clk);
        check("R1", "ser in reset", int'(ser_o), 0);
        check("R1", "flags in reset", int'(deemph_o | preshoot_o), 0);
        rst_n = 1'b1;
        sel_i = 4'd7;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R1", "ser before start", int'(ser_o), 0);
        end

        // R2 R3 R4 R5 R6 R7 R10: every code from its first bit
        for (int p = 0; p < 16; p++) begin
            int hn;
            int len;
            run_len_i = 4'd6;
            start_pat(p);
            hn  = (p == 5 || p == 6) ? 6 : L_HALF;
            len = (p == 5 || p == 6 || (p >= 10 && p <= 13)) ? 4 * hn : 60;
            expect_flags(p, "R7");
            expect_stream(p, hn, 0, len, req_of(p));
        end

        // R5: sweep every programmable length, clamped at both ends
        for (int rl = 0; rl < 16; rl++) begin
            run_len_i = 4'(rl);
            start_pat(5);
            expect_stream(5, clampn(rl), 0, 4 * clampn(rl), "R5");
        end

        // R5: length is captured at load; later changes are ignored
        run_len_i = 4'd4;
        start_pat(6);
        expect_stream(6, 4, 0, 2, "R5");
        run_len_i = 4'd12;
        expect_stream(6, 4, 2, 24, "R5");

        // R8: restart mid-stream goes back to the seed
        start_pat(9);
        expect_stream(9, L_HALF, 0, 20, "R8");
        start_pat(9);
        expect_stream(9, L_HALF, 0, 30, "R8");

        // R8: restart mid-symbol switches immediately
        start_pat(2);
        expect_stream(2, L_HALF, 0, 4, "R8");
        start_pat(3);
        expect_stream(3, L_HALF, 0, 20, "R8");

        // R9: select change inside a symbol waits for the symbol end
        start_pat(2);
        expect_stream(2, L_HALF, 0, 3, "R9");
        sel_i = 4'd8;
        expect_stream(2, L_HALF, 3, 10, "R9");
        expect_stream(8, L_HALF, 0, 16, "R9");

        // R9: select change inside a long-run period waits for the period end
        start_pat(13);
        expect_stream(13, L_HALF, 0, 4, "R9");
        sel_i = 4'd9;
        expect_stream(13, L_HALF, 4, 2 * L_HALF, "R9");
        expect_stream(9, L_HALF, 0, 30, "R9");

        // R9 / R10: byte boundary, then a reserved code parks the line
        start_pat(7);
        expect_stream(7, L_HALF, 0, 2, "R9");
        sel_i = 4'd15;
        expect_stream(7, L_HALF, 2, 8, "R9");
        expect_flags(15, "R10");
        expect_stream(15, L_HALF, 0, 12, "R10");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule